// File: doc/BRIEF.md
# Byte-Sequenced Interval Counter

This block is one channel of a programmable interval counter. It has a 16-bit down-counter. Software sets it up through an 8-bit control word and then loads and reads the count one byte at a time. The count advances only on cycles where the count-clock strobe is high and the enable input is high. The channel drives a level output pin. It also raises a one-cycle pulse at every terminal count, which can serve as an interrupt request. Several channels are built by placing several instances.

A control word carries two fields. The access field sits in bits 5:4 and the mode field in bits 3:1. An access field of 0 is a latch command: it freezes a snapshot of the count for the next reads. Any other access value sets the channel up for a low-byte-then-high-byte sequence, picks a counting mode and halts the counter. The counter starts again only after the high byte of a new count has been written. One byte pointer serves both reads and writes, and every data access flips it.

Three counting modes are available. One-shot raises the output and stops. Rate generator reloads the count. Square wave reloads the count and flips the output.

Top module: `ibc_counter`

## Requirements
- R1: A control word with access field (bits 5:4) equal to 0 captures the present count into a latch register. It changes neither the mode, the output pin nor the counting.
- R2: A control word with a nonzero access field does three things. It stores the mode field (bits 3:1), drives the output pin low on the next cycle, and halts the counter until a new load completes. Mode decode: low two mode bits 10 select rate generator, 11 select square wave, and any other value selects one-shot.
- R3: The byte pointer points at the low byte after reset and after any non-latch control word. Every data read and every data write flips it between the low and high byte.
- R4: Writing the low byte alone does not restart counting. The write of the high byte completes the load, and the counter restarts from the full new count.
- R5: Reading the high byte releases a latch, so later reads return the live count.
- R6: In one-shot mode the output pin goes high at terminal count and the counter stops at 0.
- R7: In rate-generator mode the counter reloads its initial count at terminal count and the output pin keeps its level.
- R8: In square-wave mode the output pin toggles each time the counter reloads at terminal count.
- R9: While the enable input is low, the count does not change, no terminal count occurs, and reads return the initial count.
- R10: Every terminal count (a counted tick while the count is 1) produces a tc_pulse exactly one clock long, on the cycle after that tick.
- R11: An initial count of 0 acts as 65536 ticks.
- R12: After reset the output pin and tc_pulse are low, the count and initial count are 0, no latch is held and the counter is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_data | input | 8 | Control word (access 5:4, mode 3:1) |
| data_wr | input | 1 | Count byte write strobe |
| data_rd | input | 1 | Count byte read strobe; flips the pointer at the clock edge |
| wr_data | input | DATA_W | Count byte written |
| rd_data | output | DATA_W | Count byte addressed by the pointer, valid while data_rd is high |
| cnt_tick | input | 1 | Count clock strobe, one decrement per high cycle |
| gate_en | input | 1 | Counting enable |
| out_pin | output | 1 | Channel output level |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench builds the channel with its default parameters: 8-bit bytes, a 16-bit counter and a registered terminal-count pulse. The 16-bit width keeps the 65536-tick case of a zero count short enough to run in full, so the wrap through 0xFFFF is observed at the output. The registered pulse variant fixes tc_pulse to the cycle after the counted tick, and the pulse-timing checks rely on that.

// File: rtl/ibc_pkg.sv
package ibc_pkg;
   localparam int CW_W     = 8;
   localparam int ACC_LSB  = 4;
   localparam int MODE_LSB = 1;

   typedef enum logic [1:0] {
      MD_ONESHOT = 2'd0,
      MD_RATE    = 2'd1,
      MD_SQUARE  = 2'd2
   } run_mode_e;

   function automatic run_mode_e mode_of(input logic [2:0] fld);
      case (fld[1:0])
         2'b10:   mode_of = MD_RATE;
         2'b11:   mode_of = MD_SQUARE;
         default: mode_of = MD_ONESHOT;
      endcase
   endfunction
endpackage

// File: rtl/ibc_access_port.sv
module ibc_access_port
   import ibc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CW_W-1:0]   ctl_data,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              gate_en,
   input  logic [CNT_W-1:0]  live_cnt,
   output run_mode_e         run_mode,
   output logic [CNT_W-1:0]  init_q,
   output logic              ptr_hi,
   output logic              latched,
   output logic              load_go,
   output logic              halt,
   output logic [CNT_W-1:0]  load_val,
   output logic [DATA_W-1:0] rd_data
);
   logic [1:0]       acc_fld;
   logic [2:0]       mode_fld;
   logic             is_latch;
   logic [CNT_W-1:0] latch_val;
   logic [CNT_W-1:0] view;
   logic             unused_cw;

   assign acc_fld   = ctl_data[ACC_LSB +: 2];
   assign mode_fld  = ctl_data[MODE_LSB +: 3];
   assign unused_cw = ^{ctl_data[CW_W-1:ACC_LSB+2], ctl_data[MODE_LSB-1:0]};
   assign is_latch  = (acc_fld == 2'b00);

   assign halt     = ctl_wr && !is_latch;
   assign load_go  = data_wr && ptr_hi && !ctl_wr;
   assign load_val = {wr_data, init_q[DATA_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_mode  <= MD_ONESHOT;
         init_q    <= '0;
         ptr_hi    <= 1'b0;
         latched   <= 1'b0;
         latch_val <= '0;
      end else if (ctl_wr) begin
         if (is_latch) begin
            latched   <= 1'b1;
            latch_val <= live_cnt;
         end else begin
            run_mode <= mode_of(mode_fld);
            ptr_hi   <= 1'b0;
            latched  <= 1'b0;
         end
      end else if (data_wr) begin
         if (ptr_hi) init_q[CNT_W-1:DATA_W] <= wr_data;
         else        init_q[DATA_W-1:0]     <= wr_data;
         ptr_hi <= !ptr_hi;
      end else if (data_rd) begin
         if (ptr_hi) latched <= 1'b0;
         ptr_hi <= !ptr_hi;
      end
   end

   always_comb begin
      if (!gate_en)     view = init_q;
      else if (latched) view = latch_val;
      else              view = live_cnt;
      rd_data = ptr_hi ? view[CNT_W-1:DATA_W] : view[DATA_W-1:0];
   end
endmodule

// File: rtl/ibc_down_cnt.sv
module ibc_down_cnt
   import ibc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic             load_go,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] init_q,
   input  logic             cnt_tick,
   input  logic             gate_en,
   input  run_mode_e        run_mode,
   output logic [CNT_W-1:0] cnt_q,
   output logic             tc_evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic running;
   logic step;

   assign step   = cnt_tick && gate_en && running && !halt && !load_go;
   assign tc_evt = step && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         running <= 1'b0;
      end else if (halt) begin
         running <= 1'b0;
      end else if (load_go) begin
         cnt_q   <= load_val;
         running <= 1'b1;
      end else if (tc_evt) begin
         if (run_mode == MD_ONESHOT) begin
            cnt_q   <= '0;
            running <= 1'b0;
         end else begin
            cnt_q <= init_q;
         end
      end else if (step) begin
         cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/ibc_out_stage.sv
module ibc_out_stage
   import ibc_pkg::*;
#(
   parameter bit TC_REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      halt,
   input  logic      tc_evt,
   input  run_mode_e run_mode,
   output logic      out_pin,
   output logic      tc_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_pin <= 1'b0;
      end else if (halt) begin
         out_pin <= 1'b0;
      end else if (tc_evt) begin
         case (run_mode)
            MD_ONESHOT: out_pin <= 1'b1;
            MD_SQUARE:  out_pin <= !out_pin;
            default:    out_pin <= out_pin;
         endcase
      end
   end

   generate
      if (TC_REG) begin : g_tc_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tc_pulse <= 1'b0;
            else        tc_pulse <= tc_evt;
         end
      end else begin : g_tc_comb
         assign tc_pulse = tc_evt;
      end
   endgenerate
endmodule

// File: rtl/ibc_counter.sv
module ibc_counter
   import ibc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter bit TC_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_data,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cnt_tick,
   input  logic              gate_en,
   output logic              out_pin,
   output logic              tc_pulse
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("ibc_counter: DATA_W must be positive");
      end
      if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
         $error("ibc_counter: CNT_W must equal two bytes of DATA_W");
      end
   endgenerate

   run_mode_e        run_mode;
   logic [CNT_W-1:0] init_q;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_val;
   logic             ptr_hi;
   logic             latched;
   logic             load_go;
   logic             halt;
   logic             tc_evt;

   ibc_access_port #(.DATA_W(DATA_W), .CNT_W(CNT_W)) port_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
      .data_wr(data_wr), .data_rd(data_rd), .wr_data(wr_data),
      .gate_en(gate_en), .live_cnt(cnt_val), .run_mode(run_mode),
      .init_q(init_q), .ptr_hi(ptr_hi), .latched(latched),
      .load_go(load_go), .halt(halt), .load_val(load_val),
      .rd_data(rd_data)
   );

   ibc_down_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .halt(halt), .load_go(load_go),
      .load_val(load_val), .init_q(init_q), .cnt_tick(cnt_tick),
      .gate_en(gate_en), .run_mode(run_mode), .cnt_q(cnt_val),
      .tc_evt(tc_evt)
   );

   ibc_out_stage #(.TC_REG(TC_REG)) out_i (
      .clk(clk), .rst_n(rst_n), .halt(halt), .tc_evt(tc_evt),
      .run_mode(run_mode), .out_pin(out_pin), .tc_pulse(tc_pulse)
   );
endmodule

// File: rtl/ibc_counter_chk.sv
module ibc_counter_chk
   import ibc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit TC_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic [7:0]       ctl_data,
   input logic             data_wr,
   input logic             data_rd,
   input logic             cnt_tick,
   input logic             gate_en,
   input logic             out_pin,
   input logic             tc_pulse,
   input logic [CNT_W-1:0] cnt_val,
   input run_mode_e        run_mode,
   input logic             ptr_hi,
   input logic             latched
);
   AST_LATCH_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_data[5:4] == 2'b00 && !cnt_tick) |=> ($stable(out_pin) && $stable(run_mode))); // R1
   AST_CTL_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_data[5:4] != 2'b00) |=> !out_pin); // R2
   AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !ctl_wr) |=> (ptr_hi != $past(ptr_hi))); // R3
   AST_HI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && ptr_hi && !ctl_wr && !data_wr) |=> !latched); // R5
   AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_mode == MD_ONESHOT && out_pin && !ctl_wr) |=> out_pin); // R6
   AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en && !data_wr && !ctl_wr) |=> $stable(cnt_val)); // R9

   generate
      if (TC_REG) begin : g_reg
         AST_TC_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse |-> $past(cnt_tick && gate_en)); // R10
      end else begin : g_comb
         AST_TC_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse |-> (cnt_tick && gate_en)); // R10
      end
   endgenerate
endmodule

bind ibc_counter ibc_counter_chk #(.CNT_W(CNT_W), .TC_REG(TC_REG)) chk_i (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
   .data_wr(data_wr), .data_rd(data_rd), .cnt_tick(cnt_tick),
   .gate_en(gate_en), .out_pin(out_pin), .tc_pulse(tc_pulse),
   .cnt_val(cnt_val), .run_mode(run_mode), .ptr_hi(ptr_hi),
   .latched(latched)
);

// File: tb/ibc_counter_tb_top.sv
module ibc_counter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_data = 8'h00;
   logic       data_wr = 1'b0;
   logic       data_rd = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       cnt_tick = 1'b0;
   logic       gate_en = 1'b1;
   logic       out_pin;
   logic       tc_pulse;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = !clk;

   ibc_counter dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
      .data_wr(data_wr), .data_rd(data_rd), .wr_data(wr_data),
      .rd_data(rd_data), .cnt_tick(cnt_tick), .gate_en(gate_en),
      .out_pin(out_pin), .tc_pulse(tc_pulse)
   );

   // monitor: compares each read byte against the scoreboard queue
   always @(negedge clk) begin
      if (data_rd) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL read with no expectation: actual %02h expected none", rd_data);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               failures++;
               $display("FAIL %s read: actual %02h expected %02h", t, rd_data, e);
            end
         end
      end
   end

   task automatic ctl(input logic [7:0] cw);
      @(posedge clk); #2; ctl_wr = 1'b1; ctl_data = cw;
      @(posedge clk); #2; ctl_wr = 1'b0;
   endtask

   task automatic wr(input logic [7:0] b);
      @(posedge clk); #2; data_wr = 1'b1; wr_data = b;
      @(posedge clk); #2; data_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] e, input string t);
      @(posedge clk); #2; data_rd = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk); #2; data_rd = 1'b0;
   endtask

   task automatic tick(input int n);
      @(posedge clk); #2; cnt_tick = 1'b1;
      repeat (n) @(posedge clk);
      #2; cnt_tick = 1'b0;
   endtask

   task automatic chk_pins(input logic eo, input logic et, input string t);
      @(negedge clk);
      checks++;
      if (out_pin !== eo || tc_pulse !== et) begin
         failures++;
         $display("FAIL %s pins: actual out=%b tc=%b expected out=%b tc=%b",
                  t, out_pin, tc_pulse, eo, et);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2; rst_n = 1'b1;
      // R12 reset state
      chk_pins(1'b0, 1'b0, "R12");
      rd(8'h00, "R12"); rd(8'h00, "R12");

      // R6 one-shot, R3 pointer after load
      ctl(8'h30); wr(8'h05); wr(8'h00);
      rd(8'h05, "R4"); rd(8'h00, "R3");
      tick(3);
      rd(8'h02, "R3"); rd(8'h00, "R3");
      tick(1); chk_pins(1'b0, 1'b0, "R6");
      tick(1); chk_pins(1'b1, 1'b1, "R10");
      chk_pins(1'b1, 1'b0, "R10");
      tick(4); chk_pins(1'b1, 1'b0, "R6");
      rd(8'h00, "R6"); rd(8'h00, "R6");

      // R1 latch, R5 release, R7 rate generator
      ctl(8'h34); chk_pins(1'b0, 1'b0, "R2");
      wr(8'h0A); wr(8'h00);
      tick(3);
      ctl(8'h00); chk_pins(1'b0, 1'b0, "R1");
      tick(2);
      rd(8'h07, "R1");
      tick(1);
      rd(8'h00, "R5");
      rd(8'h04, "R5"); rd(8'h00, "R5");
      tick(4); chk_pins(1'b0, 1'b1, "R7");
      rd(8'h0A, "R7"); rd(8'h00, "R7");
      tick(10); chk_pins(1'b0, 1'b1, "R7");

      // R8 square wave, R2 control word drives out low
      ctl(8'h36); wr(8'h02); wr(8'h00);
      tick(2); chk_pins(1'b1, 1'b1, "R8");
      tick(2); chk_pins(1'b0, 1'b1, "R8");
      tick(2); chk_pins(1'b1, 1'b1, "R8");
      ctl(8'h30); chk_pins(1'b0, 1'b0, "R2");

      // R9 enable low
      ctl(8'h34); wr(8'h05); wr(8'h01);
      tick(4);
      gate_en = 1'b0;
      tick(5);
      rd(8'h05, "R9"); rd(8'h01, "R9");
      gate_en = 1'b1;
      rd(8'h01, "R9"); rd(8'h01, "R9");

      // R2 halt, R4 partial load does not restart
      ctl(8'h34);
      tick(3);
      rd(8'h01, "R2"); rd(8'h01, "R2");
      wr(8'h09);
      tick(3);
      wr(8'h00);
      rd(8'h09, "R4"); rd(8'h00, "R4");

      // R9 no terminal count while disabled
      ctl(8'h30); wr(8'h01); wr(8'h00);
      gate_en = 1'b0;
      tick(3); chk_pins(1'b0, 1'b0, "R9");
      gate_en = 1'b1;
      tick(1); chk_pins(1'b1, 1'b1, "R6");

      // R11 zero count means 65536
      ctl(8'h30); wr(8'h00); wr(8'h00);
      tick(65535); chk_pins(1'b0, 1'b0, "R11");
      rd(8'h01, "R11"); rd(8'h00, "R11");
      tick(1); chk_pins(1'b1, 1'b1, "R11");

      repeat (3) @(posedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule